// File: doc/BRIEF.md
# Panel Self-Refresh Sequencer

This block walks one display pipe through the power-saving sequence in which the panel keeps showing its last frame from its own buffer while the source stops sending video. Software enables the sequencer and later requests activation. The hardware then counts vertical-blank strobes and, once enough idle frames have passed, settles into the self-refresh state. A software exit request brings the pipe back out through a wake-up handshake with the sink.

The state is reported as a three-bit code with a fixed meaning: 0 off, 1 enabled but inactive, 2 entering (static frame being sent), 3 self-refresh with no remote-buffer update, 4 single-frame update, 5 leaving. States 2, 4 and 5 are transitional. Requests that arrive during a transition are kept and acted on as soon as it ends. The link mode is captured when the block is enabled. In standby mode the main link stays up with zero training time. In link-off mode the link is powered down. While the pipe is in self-refresh, a nonzero maximum-sleep setting forces a periodic single-frame update. Software normally programs this setting to 0x1F.

Top module: `sr_panel_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state code is 0 and in_transition, link_standby, link_off and wake_req are all low.
- R2: With enable high in state 0 the state moves to 1 on the next cycle. Without an activate request it stays at 1 no matter how many frame strobes arrive.
- R3: An activate request in state 1 moves the state to 2. State 2 moves to 3 by itself one cycle after the idle-frame count reaches the threshold.
- R4: The idle threshold is cfg_idle_frames + 1, or 2 when cfg_idle_frames is 0. Frame strobes are counted only in state 2, and the count saturates at the threshold. An exit request restarts the count from zero.
- R5: An exit request in state 3 moves the state to 5 on the next cycle and never to 4. This holds even if the same cycle carries the frame strobe that would start a single-frame update.
- R6: In state 5 wake_req is high. The state stays at 5 until wake_ack is seen, and then it returns to 1.
- R7: In state 3 with cfg_max_sleep = N > 0, the Nth frame strobe since entering state 3 moves the state to 4. The next frame strobe returns it to 3. With N = 0, state 4 is never entered.
- R8: in_transition is high exactly when the state code is 2, 4 or 5.
- R9: An activate or exit request that arrives while in_transition is high is held. It takes effect on the first cycle in which in_transition is low.
- R10: cfg_link_standby is captured on the 0-to-1 step. In state 3, link_standby is high if the captured value was 1, and link_off is high if it was 0. Both are low in every other state.
- R11: With enable low, states 1 and 3 go to 0 on the next cycle, while states 2, 4 and 5 first complete their transition. In state 0, activate and exit requests are ignored and pending requests are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Source enable level |
| activate_req | input | 1 | One-cycle activate request |
| exit_req | input | 1 | One-cycle exit request |
| frame_tick | input | 1 | One-cycle vertical-blank strobe |
| cfg_idle_frames | input | IDLE_W | Configured idle frame count |
| cfg_link_standby | input | 1 | 1 = keep link in standby, 0 = power link off |
| cfg_max_sleep | input | SLEEP_W | Frames between forced single-frame updates, 0 = never |
| wake_ack | input | 1 | Sink acknowledges the D0 wake-up |
| state_code | output | 3 | Current state, 0 to 5 |
| in_transition | output | 1 | High in transitional states |
| link_standby | output | 1 | Link held in standby during self-refresh |
| link_off | output | 1 | Link powered down during self-refresh |
| wake_req | output | 1 | Request to send the D0 wake-up to the sink |

## Verification
In state 3 an exit request and the frame strobe that completes the sleep window can land in the same cycle. The bench sets the maximum sleep to one frame so that any strobe would trigger the update, then drives both together. It passes only if the next state code is 5 rather than 4. A second coincidence is an exit request held from state 2 while the idle count reaches its threshold. There the bench checks that the pipe first reports 3 and leaves for 5 on the very next cycle.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_IDLE    = 3'd1,
      ST_ENTRY   = 3'd2,
      ST_HOLD    = 3'd3,
      ST_REFRESH = 3'd4,
      ST_LEAVE   = 3'd5
   } sr_state_e;

   function automatic logic busy_state(sr_state_e s);
      return (s == ST_ENTRY) || (s == ST_REFRESH) || (s == ST_LEAVE);
   endfunction
endpackage

// File: rtl/sr_idle_cnt.sv
module sr_idle_cnt #(
   parameter int IDLE_W = 4,
   parameter bit ADJUST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clr,
   input  logic              tick,
   input  logic [IDLE_W-1:0] cfg,
   output logic              reached
);
   localparam int CW = IDLE_W + 1;

   logic [CW-1:0] thr;
   logic [CW-1:0] cnt;

   generate
      if (ADJUST) begin : g_adjust
         always_comb thr = (cfg == '0) ? CW'(2) : CW'(cfg) + CW'(1);
      end else begin : g_raw
         always_comb thr = (cfg == '0) ? CW'(1) : CW'(cfg);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run || clr)         cnt <= '0;
      else if (tick && (cnt < thr)) cnt <= cnt + CW'(1);
   end

   assign reached = run && (cnt == thr);

   // R4
   idle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R4
   idle_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= thr));
endmodule

// File: rtl/sr_sleep_cnt.sv
module sr_sleep_cnt #(
   parameter int SLEEP_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic [SLEEP_W-1:0] cfg,
   output logic               fire
);
   logic [SLEEP_W-1:0] cnt;
   logic [SLEEP_W:0]   nxt;

   assign nxt  = {1'b0, cnt} + (SLEEP_W+1)'(1);
   assign fire = run && tick && (cfg != '0) && (nxt >= {1'b0, cfg});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (!run || fire)         cnt <= '0;
      else if (tick && (cfg != '0))  cnt <= nxt[SLEEP_W-1:0];
   end

   // R7
   sleep_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg != '0) |-> (cnt < cfg));
endmodule

// File: rtl/sr_req_hold.sv
module sr_req_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic clear,
   input  logic act_req,
   input  logic exit_req,
   output logic act_eff,
   output logic exit_eff
);
   logic act_pend;
   logic exit_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_pend  <= 1'b0;
         exit_pend <= 1'b0;
      end else if (clear || !hold) begin
         act_pend  <= 1'b0;
         exit_pend <= 1'b0;
      end else begin
         act_pend  <= act_pend  | act_req;
         exit_pend <= exit_pend | exit_req;
      end
   end

   assign act_eff  = act_req  | act_pend;
   assign exit_eff = exit_req | exit_pend;

   // R9
   pend_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clear && act_req) |=> act_eff);
   // R9
   pend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clear && exit_req) |=> exit_eff);
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
   import sr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable,
   input  logic      act_eff,
   input  logic      exit_eff,
   input  logic      reached,
   input  logic      sfu_fire,
   input  logic      tick,
   input  logic      wake_ack,
   input  logic      cfg_standby,
   output sr_state_e state,
   output logic      mode_standby
);
   sr_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_OFF:     if (enable) nxt = ST_IDLE;
         ST_IDLE:    if (!enable) nxt = ST_OFF;
                     else if (act_eff) nxt = ST_ENTRY;
         ST_ENTRY:   if (reached) nxt = ST_HOLD;
         ST_HOLD:    if (!enable) nxt = ST_OFF;
                     else if (exit_eff) nxt = ST_LEAVE;
                     else if (sfu_fire) nxt = ST_REFRESH;
         ST_REFRESH: if (tick) nxt = ST_HOLD;
         ST_LEAVE:   if (wake_ack) nxt = ST_IDLE;
         default:    nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_OFF;
         mode_standby <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_OFF && enable) mode_standby <= cfg_standby;
      end
   end

   // R2
   off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF) |=> (state == ST_OFF || state == ST_IDLE));
   // R3
   idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |=> (state == ST_OFF || state == ST_IDLE || state == ST_ENTRY));
   // R5
   exit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && enable && exit_eff) |=> (state == ST_LEAVE));
   // R6
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LEAVE && !wake_ack) |=> (state == ST_LEAVE));
endmodule

// File: rtl/sr_panel_ctrl.sv
module sr_panel_ctrl
   import sr_pkg::*;
#(
   parameter int IDLE_W  = 4,
   parameter int SLEEP_W = 5,
   parameter bit ADJUST  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               activate_req,
   input  logic               exit_req,
   input  logic               frame_tick,
   input  logic [IDLE_W-1:0]  cfg_idle_frames,
   input  logic               cfg_link_standby,
   input  logic [SLEEP_W-1:0] cfg_max_sleep,
   input  logic               wake_ack,
   output logic [2:0]         state_code,
   output logic               in_transition,
   output logic               link_standby,
   output logic               link_off,
   output logic               wake_req
);
   initial begin
      param_idle_chk:  assert (IDLE_W >= 1 && IDLE_W <= 16)
         else $error("IDLE_W out of range");
      param_sleep_chk: assert (SLEEP_W >= 1 && SLEEP_W <= 16)
         else $error("SLEEP_W out of range");
   end

   sr_state_e state;
   logic      mode_standby;
   logic      busy;
   logic      act_eff, exit_eff, reached, sfu_fire;

   assign busy = busy_state(state);

   sr_req_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (busy),
      .clear    (state == ST_OFF),
      .act_req  (activate_req),
      .exit_req (exit_req),
      .act_eff  (act_eff),
      .exit_eff (exit_eff)
   );

   sr_idle_cnt #(.IDLE_W(IDLE_W), .ADJUST(ADJUST)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_ENTRY),
      .clr     (exit_req),
      .tick    (frame_tick),
      .cfg     (cfg_idle_frames),
      .reached (reached)
   );

   sr_sleep_cnt #(.SLEEP_W(SLEEP_W)) u_sleep (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_HOLD),
      .tick (frame_tick),
      .cfg  (cfg_max_sleep),
      .fire (sfu_fire)
   );

   sr_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .act_eff      (act_eff),
      .exit_eff     (exit_eff),
      .reached      (reached),
      .sfu_fire     (sfu_fire),
      .tick         (frame_tick),
      .wake_ack     (wake_ack),
      .cfg_standby  (cfg_link_standby),
      .state        (state),
      .mode_standby (mode_standby)
   );

   assign state_code    = state;
   assign in_transition = busy;
   assign wake_req      = (state == ST_LEAVE);
   assign link_standby  = (state == ST_HOLD) &&  mode_standby;
   assign link_off      = (state == ST_HOLD) && !mode_standby;

   // R6
   wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> in_transition);
   // R10
   link_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({link_standby, link_off}));
endmodule

// File: tb/sr_panel_ctrl_tb_top.sv
module sr_panel_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 24;
   // {enable, activate, exit, tick, ack, expected state[2:0]}
   localparam logic [7:0] VEC [0:NVEC-1] = '{
      8'b00000_000, 8'b10000_001, 8'b10010_001, 8'b11000_010,
      8'b10010_010, 8'b10010_010, 8'b10000_011, 8'b10010_011,
      8'b10010_011, 8'b10010_100, 8'b10000_100, 8'b10010_011,
      8'b10100_101, 8'b10000_101, 8'b11000_101, 8'b10001_001,
      8'b10000_010, 8'b10100_010, 8'b10010_010, 8'b10010_010,
      8'b10000_011, 8'b10000_101, 8'b10001_001, 8'b00000_000
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0, activate_req = 1'b0, exit_req = 1'b0;
   logic       frame_tick = 1'b0, wake_ack = 1'b0, cfg_link_standby = 1'b0;
   logic [3:0] cfg_idle_frames = 4'd0;
   logic [4:0] cfg_max_sleep = 5'd3;
   logic [2:0] state_code;
   logic       in_transition, link_standby, link_off, wake_req;
   int         nchk = 0;
   int         nfail = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sr_panel_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .activate_req(activate_req),
      .exit_req(exit_req), .frame_tick(frame_tick), .cfg_idle_frames(cfg_idle_frames),
      .cfg_link_standby(cfg_link_standby), .cfg_max_sleep(cfg_max_sleep),
      .wake_ack(wake_ack), .state_code(state_code), .in_transition(in_transition),
      .link_standby(link_standby), .link_off(link_off), .wake_req(wake_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic go(input logic e, input logic a, input logic x, input logic t, input logic k);
      enable = e; activate_req = a; exit_req = x; frame_tick = t; wake_ack = k;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 state", state_code, 0);
      chk("R1 outputs", {in_transition, link_standby, link_off, wake_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {state_code, in_transition, wake_req}, 0);

      // vector table: idle cfg 0 (threshold 2), sleep 3, link off
      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] v;
         int         es;
         v  = VEC[i];
         es = int'(v[2:0]);
         go(v[7], v[6], v[5], v[4], v[3]);
         chk($sformatf("R3/R9 row %0d state", i), state_code, es);
         chk($sformatf("R8 row %0d busy", i), in_transition, (es == 2 || es == 4 || es == 5) ? 1 : 0);
         chk($sformatf("R6 row %0d wake", i), wake_req, (es == 5) ? 1 : 0);
      end

      // R4 threshold cfg 3 -> 4 frames; R10 standby captured
      cfg_idle_frames = 4'd3; cfg_link_standby = 1'b1; cfg_max_sleep = 5'd0;
      go(1,0,0,0,0);
      chk("R10 links low in state 1", {link_standby, link_off}, 0);
      go(1,1,0,0,0);
      repeat (3) go(1,0,0,1,0);
      go(1,0,0,0,0);
      chk("R4 below threshold", state_code, 2);
      go(1,0,0,1,0);
      go(1,0,0,0,0);
      chk("R4 threshold reached", state_code, 3);
      chk("R10 standby", {link_standby, link_off}, 2);
      cfg_link_standby = 1'b0;
      go(1,0,0,0,0);
      chk("R10 mode captured", {link_standby, link_off}, 2);

      // R7 zero sleep never updates
      repeat (40) go(1,0,0,1,0);
      chk("R7 zero sleep", state_code, 3);

      // R5 exit and update strobe together
      cfg_max_sleep = 5'd1;
      go(1,0,1,1,0);
      chk("R5 exit wins", state_code, 5);

      // R6 wake handshake
      repeat (10) go(1,0,0,0,0);
      chk("R6 wait for ack", {state_code, wake_req}, {3'd5, 1'b1});
      go(1,0,0,0,1);
      chk("R6 ack returns", state_code, 1);

      // R4 exit restarts count, R9 pending exit
      cfg_idle_frames = 4'd0;
      go(1,1,0,0,0);
      go(1,0,0,1,0);
      go(1,0,1,0,0);
      go(1,0,0,1,0);
      go(1,0,0,0,0);
      chk("R4 count restarted", state_code, 2);
      go(1,0,0,1,0);
      go(1,0,0,0,0);
      chk("R3 auto entry", state_code, 3);
      go(1,0,0,0,0);
      chk("R9 pending exit served", state_code, 5);
      go(1,0,0,0,1);

      // R7 single-frame update with sleep 1
      go(1,1,0,0,0);
      go(1,0,0,1,0);
      go(1,0,0,1,0);
      go(1,0,0,0,0);
      go(1,0,0,1,0);
      chk("R7 update entered", state_code, 4);
      chk("R10 links low in state 4", {link_standby, link_off}, 0);
      go(1,0,0,1,0);
      chk("R7 update done", state_code, 3);

      // R11 disable during entry completes first
      go(1,0,1,0,0);
      go(1,0,0,0,1);
      go(1,1,0,0,0);
      go(0,0,0,1,0);
      go(0,0,0,0,0);
      chk("R11 entry continues", state_code, 2);
      go(0,0,0,1,0);
      go(0,0,0,0,0);
      chk("R11 entry completes", state_code, 3);
      go(0,0,0,0,0);
      chk("R11 disabled", state_code, 0);
      go(0,1,1,0,0);
      go(0,0,0,0,0);
      chk("R11 requests ignored", {state_code, in_transition}, 0);

      // R2 enable alone never enters
      go(1,0,0,0,0);
      chk("R2 enabled", state_code, 1);
      repeat (50) go(1,0,0,1,0);
      chk("R2 no entry without activate", state_code, 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule